// File: doc/BRIEF.md
# Chained descriptor DMA sequencer

A single-channel transfer engine that works through a table of descriptors held in its own registers. Each descriptor gives a source address, a destination address, a byte count, the index of the descriptor to run next and three control flags. On a start pulse the engine loads the chosen descriptor and splits its transfer into bursts. It presents each burst as one request on a simple memory port and holds the request until the port acknowledges it. After the last burst of a descriptor it follows the link to the next one.

Links are plain indices, so one descriptor can point to itself to repeat a pattern forever. Two descriptors that point at each other form a ping-pong pair, and a longer loop forms a ring of buffers. A flag ends the chain. A stall input holds off new bursts. A cancel input stops the channel at the next burst boundary. The engine raises two kinds of interrupt pulse: one when a flagged descriptor completes, and one when the chain terminates.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req`, `irq_td` and `irq_chain` are all low.
- R2: A write on the configuration port stores the descriptor at `cfg_idx`. The control bits are: bit 0 marks the end of the chain, bit 1 requests a pulse when the descriptor completes, and bit 2 makes the transfer unbounded.
- R3: A descriptor's bytes are moved in bursts of min(remaining, 127). The first burst uses the stored addresses. Both addresses then advance by each burst's length, wrapping at the address width.
- R4: The stored count is the byte count minus one, which gives a range of 1 to 65536 bytes per descriptor.
- R5: An unbounded descriptor never completes. It issues 127-byte bursts with advancing addresses until it is cancelled.
- R6: When a descriptor completes and its end-of-chain bit is clear, the descriptor at its next index is loaded. This covers self-loops, ping-pong pairs and rings.
- R7: When a descriptor with the end-of-chain bit completes, `irq_chain` pulses high for one cycle in the cycle after the final acknowledge, and `busy` is low in that same cycle.
- R8: `irq_td` pulses for one cycle in the cycle after the final acknowledge of a descriptor whose completion bit is set. It stays low after every other acknowledge.
- R9: While `stall` is high, no new request is raised. Once `stall` falls, the bursts continue with unchanged addresses and lengths.
- R10: With `cancel` high, the channel returns to idle at the next burst boundary without raising a further request. A request that is already raised still completes.
- R11: A descriptor may be rewritten while the channel runs. The new contents take effect the next time that descriptor is loaded.
- R12: A raised request keeps its addresses and length unchanged until `mem_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 7 | Descriptor index to write |
| cfg_src | input | 16 | Source address |
| cfg_dst | input | 16 | Destination address |
| cfg_len_m1 | input | 16 | Byte count minus one |
| cfg_next | input | 7 | Index of the next descriptor |
| cfg_ctrl | input | 3 | {unbounded, irq on done, end of chain} |
| start | input | 1 | Start pulse, taken only when idle |
| start_idx | input | 7 | First descriptor of the chain |
| stall | input | 1 | Hold off new bursts |
| cancel | input | 1 | Stop at the next burst boundary |
| mem_req | output | 1 | Burst request |
| mem_src | output | 16 | Burst source address |
| mem_dst | output | 16 | Burst destination address |
| mem_len | output | 7 | Burst length in bytes |
| mem_ack | input | 1 | Burst done, one-cycle pulse |
| busy | output | 1 | Channel active |
| irq_td | output | 1 | Descriptor-done pulse |
| irq_chain | output | 1 | Chain-terminated pulse |

## Verification
The assertions assume that `mem_ack` arrives only while `mem_req` is high and lasts one cycle. They also assume that `start` is pulsed only while the channel is idle. The bench's memory model raises the acknowledge only after it has seen a request, drops it at the next falling edge, and varies its delay between zero and two cycles. Every start is issued from an idle channel. Cancel is raised together with an acknowledge and is held until the channel is idle.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW    = 16,
  parameter int IDX_W = 7,
  parameter int LW    = 16,
  parameter int MAXB  = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [LW-1:0]    cfg_len_m1,
  input  logic [IDX_W-1:0] cfg_next,
  input  logic [2:0]       cfg_ctrl,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             stall,
  input  logic             cancel,
  output logic             mem_req,
  output logic [AW-1:0]    mem_src,
  output logic [AW-1:0]    mem_dst,
  output logic [$clog2(MAXB+1)-1:0] mem_len,
  input  logic             mem_ack,
  output logic             busy,
  output logic             irq_td,
  output logic             irq_chain
);
  localparam int ND = 1 << IDX_W;
  localparam int BW = $clog2(MAXB+1);
  localparam int DW = 2*AW + LW + IDX_W + 3;
  localparam logic [BW-1:0] MAXL = BW'(MAXB);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ISSUE, S_WAIT} st_t;

  logic [DW-1:0]    tbl [ND];
  st_t              st;
  logic [IDX_W-1:0] idx_q, nxt_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [LW:0]      rem_q;
  logic [2:0]       ctl_q;

  logic [2:0]       l_ctl;
  logic [IDX_W-1:0] l_nxt;
  logic [LW-1:0]    l_lm1;
  logic [AW-1:0]    l_src, l_dst;
  logic [BW-1:0]    blen;
  logic             td_done;

  always_ff @(posedge clk)
    if (cfg_we) tbl[cfg_idx] <= {cfg_ctrl, cfg_next, cfg_len_m1, cfg_dst, cfg_src};

  assign {l_ctl, l_nxt, l_lm1, l_dst, l_src} = tbl[idx_q];

  assign blen    = (ctl_q[2] || rem_q > (LW+1)'(MAXB)) ? MAXL : rem_q[BW-1:0];
  assign td_done = !ctl_q[2] && rem_q == (LW+1)'(blen);

  assign busy    = st != S_IDLE;
  assign mem_req = st == S_WAIT;
  assign mem_src = src_q;
  assign mem_dst = dst_q;
  assign mem_len = blen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx_q     <= '0;
      nxt_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      rem_q     <= '0;
      ctl_q     <= '0;
      irq_td    <= 1'b0;
      irq_chain <= 1'b0;
    end else begin
      irq_td    <= 1'b0;
      irq_chain <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            idx_q <= start_idx;
            st    <= S_LOAD;
          end
        S_LOAD: begin
          src_q <= l_src;
          dst_q <= l_dst;
          rem_q <= {1'b0, l_lm1} + 1'b1;
          nxt_q <= l_nxt;
          ctl_q <= l_ctl;
          st    <= S_ISSUE;
        end
        S_ISSUE:
          if (cancel)      st <= S_IDLE;
          else if (!stall) st <= S_WAIT;
        S_WAIT:
          if (mem_ack) begin
            src_q <= src_q + AW'(blen);
            dst_q <= dst_q + AW'(blen);
            if (!ctl_q[2]) rem_q <= rem_q - (LW+1)'(blen);
            if (td_done) begin
              irq_td <= ctl_q[1];
              if (ctl_q[0]) begin
                irq_chain <= 1'b1;
                st        <= S_IDLE;
              end else begin
                idx_q <= nxt_q;
                st    <= S_LOAD;
              end
            end else begin
              st <= S_ISSUE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0 && mem_len <= MAXL));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_src) && $stable(mem_dst) && $stable(mem_len)));

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && stall) |=> !mem_req);

  p_chain_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_chain |-> !busy);

  p_cancel_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ISSUE && cancel) |=> (!busy && !mem_req));

  p_irq_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_td || irq_chain) |-> $past(mem_ack));
endmodule

// File: tb/dma_chain_seq_bench.sv
`timescale 1ns/1ps
module dma_chain_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_idx = '0, cfg_next = '0, start_idx = '0;
  logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_len_m1 = '0;
  logic [2:0] cfg_ctrl = '0;
  logic start = 1'b0, stall = 1'b0, cancel = 1'b0, mem_ack = 1'b0;
  logic mem_req, busy, irq_td, irq_chain;
  logic [15:0] mem_src, mem_dst;
  logic [6:0] mem_len;

  int vecs = 0, bad = 0;
  logic [15:0] b_src [64], b_dst [64];
  logic [15:0] b_lm1 [64];
  logic [6:0]  b_nx  [64];
  logic [2:0]  b_ctl [64];

  always #10 clk = ~clk;

  dma_chain_seq u_dma_chain_seq (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_src, .cfg_dst, .cfg_len_m1, .cfg_next,
    .cfg_ctrl, .start, .start_idx, .stall, .cancel, .mem_req, .mem_src, .mem_dst,
    .mem_len, .mem_ack, .busy, .irq_td, .irq_chain);

  task automatic chk(string r, bit ok, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic put(int i, logic [15:0] s, logic [15:0] d, int len, int nx, logic [2:0] c);
    b_src[i] = s; b_dst[i] = d; b_lm1[i] = 16'(len - 1); b_nx[i] = 7'(nx); b_ctl[i] = c;
    cfg_idx = 7'(i); cfg_src = s; cfg_dst = d; cfg_len_m1 = 16'(len - 1);
    cfg_next = 7'(nx); cfg_ctrl = c; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick(int i);
    start_idx = 7'(i); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic serve(logic [15:0] s, logic [15:0] d, logic [6:0] len,
                       bit etd, bit ech, bit cxl, int dly);
    int t = 0;
    while (!mem_req && t < 5000) begin @(negedge clk); t++; end
    chk("R3 burst", mem_req && mem_src == s && mem_dst == d && mem_len == len,
        64'({mem_req, mem_src, mem_dst, mem_len}), 64'({1'b1, s, d, len}));
    if (dly > 0) begin
      repeat (dly) @(negedge clk);
      chk("R12 hold", mem_req && mem_src == s && mem_dst == d && mem_len == len,
          64'({mem_req, mem_src, mem_len}), 64'({1'b1, s, len}));
    end
    if (cxl) cancel = 1'b1;
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R8 irq_td", irq_td == etd, 64'(irq_td), 64'(etd));
    chk("R7 irq_chain", irq_chain == ech, 64'(irq_chain), 64'(ech));
    if (ech) chk("R7 idle", !busy, 64'(busy), 64'd0);
    if (cxl) begin
      repeat (3) @(negedge clk);
      cancel = 1'b0;
      chk("R10 cancel", !busy && !mem_req, 64'({busy, mem_req}), 64'd0);
    end
  endtask

  task automatic run(int first, int maxd, int infb);
    int i = first;
    kick(first);
    for (int k = 0; k < maxd; k++) begin
      logic [15:0] s = b_src[i], d = b_dst[i];
      bit inf = b_ctl[i][2];
      int rem = int'(b_lm1[i]) + 1;
      int n = 0;
      forever begin
        logic [6:0] len = (inf || rem > 127) ? 7'd127 : 7'(rem);
        bit fin  = !inf && rem == int'(len);
        bit stop = fin && b_ctl[i][0];
        bit cx   = !stop && k == maxd - 1 && (inf ? n == infb - 1 : fin);
        serve(s, d, len, fin && b_ctl[i][1], stop, cx, n % 3);
        s += 16'(len); d += 16'(len);
        if (!inf) rem -= int'(len);
        n++;
        if (stop || cx) return;
        if (fin) break;
      end
      i = int'(b_nx[i]);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    chk("watchdog", 1'b0, 64'(cyc), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int lens [11] = '{1, 2, 126, 127, 128, 253, 254, 255, 381, 1000, 65536};
    repeat (3) @(negedge clk);
    chk("R1 reset", !busy && !mem_req && !irq_td && !irq_chain,
        64'({busy, mem_req, irq_td, irq_chain}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R3 sweep of byte counts, one terminating descriptor each
    foreach (lens[j]) begin
      put(0, 16'(16'h1000 + j * 16'h0111), 16'(16'h8000 + j), lens[j], 0, 3'b011);
      run(0, 1, 0);
    end
    // R3 address wrap
    put(1, 16'hFFF0, 16'hFF80, 300, 1, 3'b001);
    run(1, 1, 0);

    // R6 ring of four, walked twice and a bit, cancelled at a boundary
    put(10, 16'h2000, 16'h3000, 3,   11, 3'b010);
    put(11, 16'h2100, 16'h3100, 200, 12, 3'b000);
    put(12, 16'h2200, 16'h3200, 127, 13, 3'b010);
    put(13, 16'h2300, 16'h3300, 50,  10, 3'b000);
    run(10, 9, 0);

    // R6 ping-pong pair and self-loop
    put(20, 16'h4000, 16'h5000, 130, 21, 3'b010);
    put(21, 16'h4400, 16'h5400, 64,  20, 3'b010);
    run(20, 5, 0);
    put(30, 16'h6000, 16'h7000, 10, 30, 3'b010);
    run(30, 4, 0);

    // R6 R7 R8 two-entry chain ending on the second entry
    put(50, 16'h0100, 16'h0200, 20, 51, 3'b010);
    put(51, 16'h0300, 16'h0400, 5,  50, 3'b001);
    run(50, 2, 0);

    // R5 unbounded descriptor, cancelled after seven bursts
    put(40, 16'hFE00, 16'h0010, 1, 40, 3'b110);
    run(40, 1, 7);

    // R9 stall held from the start, then released
    put(4, 16'h0A00, 16'h0B00, 140, 4, 3'b011);
    stall = 1'b1;
    kick(4);
    repeat (8) @(negedge clk);
    chk("R9 stalled", !mem_req && busy, 64'({mem_req, busy}), 64'b01);
    stall = 1'b0;
    serve(16'h0A00, 16'h0B00, 7'd127, 1'b0, 1'b0, 1'b0, 0);
    stall = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 mid stall", !mem_req && busy, 64'({mem_req, busy}), 64'b01);
    stall = 1'b0;
    serve(16'h0A7F, 16'h0B7F, 7'd13, 1'b1, 1'b1, 1'b0, 0);

    // R11 rewrite of a ping-pong entry while the channel runs
    put(60, 16'hC000, 16'hD000, 5, 61, 3'b010);
    put(61, 16'hC100, 16'hD100, 6, 60, 3'b000);
    kick(60);
    serve(16'hC000, 16'hD000, 7'd5, 1'b1, 1'b0, 1'b0, 0);
    put(60, 16'hE000, 16'hF000, 9, 61, 3'b011);
    serve(16'hC100, 16'hD100, 7'd6, 1'b0, 1'b0, 1'b0, 1);
    serve(16'hE000, 16'hF000, 7'd9, 1'b1, 1'b1, 1'b0, 0);

    // R2 idle channel ignores cancel and stall, start still works
    cancel = 1'b1; stall = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 idle", !busy && !mem_req, 64'({busy, mem_req}), 64'd0);
    cancel = 1'b0; stall = 1'b0;
    put(5, 16'h1234, 16'h4321, 7, 5, 3'b001);
    run(5, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule